// File: doc/BRIEF.md
# Serial flash command sequencer

This block runs one software-launched command against a serial NOR flash. A 32-bit control word sets up the whole command. It holds the opcode and a set of phase controls: an optional address of one to four bytes, an optional mode byte, a count of 0 to 31 dummy bytes, and optional write or read data of one to eight bytes. The separate inputs `cmd_addr`, `mode_byte` and `wr_data` supply the address, the mode value and the outgoing data. They must stay steady while the block is busy. A write of the control word with bit 0 set launches the command. The block then drives chip select, a mode-0 serial clock and up to four data lanes with per-lane output enables.

A 2-bit lane-width input is captured at launch and applies to every phase, the opcode included. The serial clock half-period is `clk_half` system clocks. Received bytes are packed into a 64-bit result. A read-back port shows the stored control fields and a busy flag.

Top module: `serial_flash_cmd`

## Requirements
- R1: A control write with bit 0 set while idle starts a command at the next clock. Chip select goes low and `busy` (also read-back bit 1) stays high until chip select is released. A write with bit 0 clear only stores the fields and starts nothing.
- R2: Any control write, with or without bit 0, that arrives while busy is ignored: the running transfer and the stored fields are unchanged.
- R3: Phases run in the order opcode (bits 31:24), address, mode, dummy, write data, read data. Every byte is shifted most significant bit first.
- R4: Bit 19 enables the address phase. Bits 17:16 give its length (00→1, 01→2, 10→3, 11→4 bytes), taken from the low bytes of `cmd_addr` and sent highest byte first.
- R5: Bit 18 enables a single `mode_byte` phase sent right after the address.
- R6: Bits 11:7 give 0 to 31 dummy bytes. During dummy and read bytes, and whenever the block is idle, all output enables are low.
- R7: Bit 15 enables write data. Bits 14:12 give the byte count minus one. `wr_data[7:0]` is sent first.
- R8: Bit 23 enables read data. Bits 22:20 give the byte count minus one. The first received byte lands in `rd_data[7:0]`, and unreceived bytes read zero. `rd_data` changes only during a command and is final when `busy` falls.
- R9: `lane_mode` 00 selects one lane (out on DQ0, in on DQ1), 01 two lanes (DQ1:DQ0), 10 four lanes (DQ3:DQ0), and 11 acts as 00. Within each clock the higher-order bit goes on the higher lane, so a byte takes 8, 4 or 2 clocks.
- R10: The serial clock idles low and each level lasts `clk_half` system clocks (0 acts as 1). Chip select falls one half-period before the first rising edge and rises one half-period after the last falling edge. Data changes only at falling edges, and input is sampled at rising edges.
- R11: The read-back word returns the stored bits 31:7, zero in bits 6:2 and 0, and the busy flag in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Control word write strobe |
| cmd_wdata | input | 32 | Control word write data |
| cmd_rdata | output | 32 | Control word read-back with busy flag |
| lane_mode | input | 2 | Lane width select, captured at launch |
| clk_half | input | DIVW | Serial clock half-period in system clocks |
| cmd_addr | input | 32 | Command address |
| mode_byte | input | 8 | Mode byte value |
| wr_data | input | 64 | Write data, first byte in bits 7:0 |
| rd_data | output | 64 | Read result, first byte in bits 7:0 |
| busy | output | 1 | Command in progress |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| dq_out | output | 4 | Data lane outputs |
| dq_oe | output | 4 | Per-lane output enables |
| dq_in | input | 4 | Data lane inputs |

## Verification
The hardest case to reach from the ports is a control write that arrives in the middle of a running transfer. It needs a launch whose timing the stimulus tracks to the exact clock, then a second write with a different opcode and bit 0 set, placed at a chosen count inside the transfer. The bench's cycle model keeps its expected waveform for the first command and compares the lines and the read-back on every clock. A second hard case is the check that zero fill of the result is separate from the data of an earlier command. For it, a long read is followed by a short read, and the bench drives non-matching values on the lanes outside read bytes.

// File: rtl/serial_flash_cmd.sv
`timescale 1ns/1ps
module serial_flash_cmd #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [31:0]     cmd_wdata,
  output logic [31:0]     cmd_rdata,
  input  logic [1:0]      lane_mode,
  input  logic [DIVW-1:0] clk_half,
  input  logic [31:0]     cmd_addr,
  input  logic [7:0]      mode_byte,
  input  logic [63:0]     wr_data,
  output logic [63:0]     rd_data,
  output logic            busy,
  output logic            cs_n,
  output logic            sclk,
  output logic [3:0]      dq_out,
  output logic [3:0]      dq_oe,
  input  logic [3:0]      dq_in
);

  typedef enum logic [1:0] {IDLE, SHIFT, TRAIL} state_t;

  state_t          state;
  logic [31:0]     cfg;
  logic [1:0]      wm;
  logic [DIVW-1:0] hc;
  logic [5:0]      bc;
  logic [2:0]      sc;
  logic [7:0]      rsh;

  wire unused_bits = ^cmd_wdata[6:1];

  assign busy      = (state != IDLE);
  assign cmd_rdata = {cfg[31:7], 5'b0, busy, 1'b0};

  wire launch = cmd_wr && !busy && cmd_wdata[0];
  wire tick   = ({1'b0, hc} + 1'b1) >= {1'b0, clk_half};

  wire [2:0] na = cfg[19] ? 3'(cfg[17:16]) + 3'd1 : 3'd0;
  wire [3:0] nw = cfg[15] ? 4'(cfg[14:12]) + 4'd1 : 4'd0;
  wire [3:0] nr = cfg[23] ? 4'(cfg[22:20]) + 4'd1 : 4'd0;

  wire [5:0] e_addr = 6'd1 + 6'(na);
  wire [5:0] e_mode = e_addr + 6'(cfg[18]);
  wire [5:0] e_dum  = e_mode + 6'(cfg[11:7]);
  wire [5:0] e_wr   = e_dum + 6'(nw);
  wire [5:0] e_rd   = e_wr + 6'(nr);

  wire [1:0] ak = 2'(e_addr - 6'd1 - bc);
  wire [2:0] wi = 3'(bc - e_dum);
  wire [2:0] ri = 3'(bc - e_wr);

  logic [7:0] cur;
  logic       drive, is_rd;

  always_comb begin
    cur   = 8'h00;
    drive = 1'b1;
    is_rd = 1'b0;
    if (bc == 6'd0)       cur = cfg[31:24];
    else if (bc < e_addr) cur = cmd_addr[{ak, 3'b000} +: 8];
    else if (bc < e_mode) cur = mode_byte;
    else if (bc < e_dum)  drive = 1'b0;
    else if (bc < e_wr)   cur = wr_data[{wi, 3'b000} +: 8];
    else begin
      drive = 1'b0;
      is_rd = 1'b1;
    end
  end

  wire [2:0] last_sc = (wm == 2'd0) ? 3'd7 : (wm == 2'd1) ? 3'd3 : 3'd1;
  wire [3:0] shamt   = (wm == 2'd0) ? {1'b0, sc} : (wm == 2'd1) ? {sc, 1'b0} : {sc[1:0], 2'b00};
  wire [7:0] sh      = cur << shamt;
  wire [3:0] lanes   = (wm == 2'd0) ? 4'b0001 : (wm == 2'd1) ? 4'b0011 : 4'b1111;
  wire [3:0] bits    = (wm == 2'd0) ? {3'b0, sh[7]} : (wm == 2'd1) ? {2'b0, sh[7:6]} : sh[7:4];
  wire       act     = (state == SHIFT) && drive;

  assign dq_oe  = act ? lanes : 4'b0000;
  assign dq_out = act ? bits  : 4'b0000;

  wire [7:0] rsh_nx = (wm == 2'd0) ? {rsh[6:0], dq_in[1]} :
                      (wm == 2'd1) ? {rsh[5:0], dq_in[1:0]} : {rsh[3:0], dq_in};
  wire last_unit = (sc == last_sc) && (bc == e_rd - 6'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      cfg     <= '0;
      wm      <= 2'd0;
      hc      <= '0;
      bc      <= 6'd0;
      sc      <= 3'd0;
      rsh     <= 8'h00;
      rd_data <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
    end else begin
      if (cmd_wr && !busy) cfg <= {cmd_wdata[31:7], 7'b0};
      if (launch) begin
        state   <= SHIFT;
        cs_n    <= 1'b0;
        hc      <= '0;
        bc      <= 6'd0;
        sc      <= 3'd0;
        rd_data <= '0;
        wm      <= (lane_mode == 2'b01) ? 2'd1 : (lane_mode == 2'b10) ? 2'd2 : 2'd0;
      end else if (busy) begin
        if (!tick) hc <= hc + 1'b1;
        else begin
          hc <= '0;
          if (state == TRAIL) begin
            cs_n  <= 1'b1;
            state <= IDLE;
          end else if (!sclk) begin
            sclk <= 1'b1;
            if (is_rd) begin
              if (sc == last_sc) rd_data[{ri, 3'b000} +: 8] <= rsh_nx;
              else               rsh <= rsh_nx;
            end
          end else begin
            sclk <= 1'b0;
            if (last_unit) state <= TRAIL;
            else if (sc == last_sc) begin
              sc <= 3'd0;
              bc <= bc + 6'd1;
            end else sc <= sc + 3'd1;
          end
        end
      end
    end
  end

  AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !cs_n); // R1
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && cmd_wr) |=> $stable(cfg)); // R2
  AST_IDLE_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (!sclk && dq_oe == 4'b0000)); // R10
  AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !cmd_wr) |=> $stable(rd_data)); // R8
  AST_SINGLE_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n) (busy && wm == 2'd0) |-> dq_oe[3:1] == 3'b000); // R9
  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> !cs_n); // R10

endmodule

// File: tb/sim_serial_flash_cmd.sv
`timescale 1ns/1ps
module sim_serial_flash_cmd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [1:0]  lane_mode = 2'b00;
  logic [7:0]  clk_half = 8'd1;
  logic [31:0] cmd_addr = '0;
  logic [7:0]  mode_byte = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        busy, cs_n, sclk;
  logic [3:0]  dq_out, dq_oe;
  logic [3:0]  dq_in = 4'hF;

  int vec = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  serial_flash_cmd #(.DIVW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .lane_mode(lane_mode), .clk_half(clk_half),
    .cmd_addr(cmd_addr), .mode_byte(mode_byte), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .cs_n(cs_n), .sclk(sclk),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input bit rd, input int nrd,
                                     input bit ad, input int nad, input bit md,
                                     input bit wr, input int nwr, input int nd);
    return {op, rd, 3'(nrd - 1), ad, md, 2'(nad - 1), wr, 3'(nwr - 1), 5'(nd), 6'b0, 1'b1};
  endfunction

  task automatic run(input logic [31:0] w, input logic [1:0] it, input int h,
                     input logic [31:0] a, input logic [7:0] m, input logic [63:0] wd,
                     input logic [63:0] rp, input int poke);
    logic [7:0] bq[$];
    int         kq[$];
    logic [3:0] eo[$], eoe[$], rin[$];
    logic [63:0] exp_rd = '0;
    int L = (it == 2'b01) ? 2 : (it == 2'b10) ? 4 : 1;
    logic [3:0] mask = 4'((1 << L) - 1);
    int hh = (h < 1) ? 1 : h;
    int U;
    bq.push_back(w[31:24]); kq.push_back(0);
    if (w[19]) for (int k = int'(w[17:16]); k >= 0; k--) begin bq.push_back(a[8*k +: 8]); kq.push_back(0); end
    if (w[18]) begin bq.push_back(m); kq.push_back(0); end
    for (int d = 0; d < int'(w[11:7]); d++) begin bq.push_back(8'h00); kq.push_back(1); end
    if (w[15]) for (int j = 0; j <= int'(w[14:12]); j++) begin bq.push_back(wd[8*j +: 8]); kq.push_back(0); end
    if (w[23]) for (int j = 0; j <= int'(w[22:20]); j++) begin
      bq.push_back(rp[8*j +: 8]); kq.push_back(2); exp_rd[8*j +: 8] = rp[8*j +: 8];
    end
    for (int i = 0; i < bq.size(); i++)
      for (int s = 0; s < 8 / L; s++) begin
        logic [7:0] t = bq[i] >> (8 - L * (s + 1));
        logic [3:0] b = t[3:0] & mask;
        eo.push_back(kq[i] == 0 ? b : 4'h0);
        eoe.push_back(kq[i] == 0 ? mask : 4'h0);
        rin.push_back(kq[i] == 2 ? (L == 1 ? {2'b0, b[0], 1'b0} : b) : ~b);
      end
    U = eo.size();
    @(negedge clk);
    cmd_addr = a; mode_byte = m; wr_data = wd; lane_mode = it; clk_half = 8'(h);
    cmd_wdata = w; cmd_wr = 1'b1; dq_in = rin[0];
    @(negedge clk);
    for (int n = 0; n <= (2 * U + 1) * hh; n++) begin
      int u = n / (2 * hh);
      cmd_wr = 1'b0;
      if (n < 2 * U * hh) begin
        chk("R10 cs/sclk/busy", {cs_n, sclk, busy}, {1'b0, 1'((n / hh) % 2), 1'b1});
        chk("R9 lane enables", dq_oe, eoe[u]);
        chk("R3 lane data", dq_out, eo[u]);
      end else if (n < (2 * U + 1) * hh) begin
        chk("R10 trailing half-period", {cs_n, sclk, busy, dq_oe}, {3'b001, 4'h0});
      end else begin
        chk("R1 release", {cs_n, sclk, busy, dq_oe}, {3'b100, 4'h0});
        chk("R8 read result", rd_data, exp_rd);
        chk("R11 read-back", cmd_rdata, {w[31:7], 7'b0});
      end
      if (n == 1) chk("R11 busy bit", cmd_rdata[1:0], 2'b10);
      if (n == poke) begin
        cmd_wdata = 32'h9F80_F001; cmd_wr = 1'b1;
      end
      dq_in = (u < U) ? rin[u] : 4'hF;
      if (n < (2 * U + 1) * hh) @(negedge clk);
    end
    cmd_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {cs_n, sclk, busy, dq_oe, dq_out}, {3'b100, 8'h00});
    chk("R8 reset result", rd_data, 64'h0);
    chk("R11 reset read-back", cmd_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: fields only, no launch
    cmd_wdata = mk(8'hC7, 1, 4, 1, 3, 0, 0, 1, 5) & ~32'h1; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R1 no launch without bit0", {cs_n, busy}, 2'b10);
      @(negedge clk);
    end
    chk("R11 stored fields", cmd_rdata, {cmd_wdata[31:7], 7'b0});
    // R3: opcode only
    run(mk(8'h06, 0, 1, 0, 1, 0, 0, 1, 0), 2'b00, 2, '0, '0, '0, '0, -1);
    // R4: erase with 3 address bytes
    run(mk(8'h20, 0, 1, 1, 3, 0, 0, 1, 0), 2'b00, 1, 32'hAB12_3456, '0, '0, '0, -1);
    // R8, R6: single-lane read, 8 bytes
    run(mk(8'h0B, 1, 8, 1, 3, 0, 0, 1, 1), 2'b00, 2, 32'h0001_0203, '0, '0, 64'h8877_6655_4433_2211, -1);
    // R7, R5, R9: quad write, 4-byte address
    run(mk(8'h32, 0, 1, 1, 4, 1, 1, 5, 0), 2'b10, 3, 32'hDEAD_BEEF, 8'hA5, 64'h0000_00C3_5A96_69F0, '0, -1);
    // R2, R9: dual read with mode and dummy, mid-run write ignored, zero fill
    run(mk(8'hBB, 1, 3, 1, 2, 1, 0, 1, 2), 2'b01, 1, 32'h0000_7E81, 8'h3C, '0, 64'hFFFF_FFFF_FF5A_C3E7, 9);
    // R9: code 11 acts as single lane
    run(mk(8'h5A, 1, 1, 1, 2, 0, 1, 2, 0), 2'b11, 1, 32'h0000_1234, '0, 64'h0000_0000_0000_B7E2, 64'h0000_0000_0000_0096, -1);
    // R6: 31 dummy bytes in quad, clk_half 0 acts as 1
    run(mk(8'hEB, 1, 2, 0, 1, 0, 0, 1, 31), 2'b10, 0, '0, '0, '0, 64'h0000_0000_0000_4DB2, -1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule